// File: doc/BRIEF.md
# Privileged Exception Entry and Return Sequencer

This block works out where the core goes when a fault, trap or interrupt is taken, and where it goes when privileged code executes its return instruction. On a taken event it adds a per-event vector offset to the handler base register and produces the handler address and the address after it. It also decides whether the saved restart address must be rewritten, and with what value. It requests a switch into the shadow register bank when the event arrives from outside privileged mode. On a return it redirects to the saved restart address. It asks to leave the shadow bank when that address's mode bit is clear, and it raises a one-cycle "check interrupts" pulse.

Bit 0 of any program counter marks privileged mode. Every vector offset has bit 0 set, so a handler always runs privileged. The sequencer holds no registers of the architecture. It reads the current PC, the handler base and the saved restart address from its inputs, and it reports the update as one-cycle strobes with their data. After reset it issues the reset redirect once by itself.

Top module: `pal_seq_top`

## Requirements
- R1: While `rst_n` is low every strobe output is 0. In the first cycle after `rst_n` rises, `redir_o` is 1, `new_pc_o` is `pal_base_i + 0x0001` and `shadow_enter_o` is 1, with no restart-address write. A take or return presented in that cycle is ignored.
- R2: On `take_i`, `new_pc_o` is `pal_base_i` plus the offset for `fault_code_i`: 0 interrupt 0x0101, 1 instruction-map miss 0x0181, 2 instruction-map access violation 0x0081, 3 data-map miss from user code 0x0201, 4 data-map miss from privileged code 0x0281, 5 misalignment 0x0301, 6 data-map fault 0x0381, 7 machine check 0x0401, 8 unimplemented opcode 0x0481, 9 arithmetic 0x0501, 11 floating-point disabled 0x0581, 12 privileged call 0x2001, 13 reset 0x0001.
- R3: Code 10 (integer overflow) selects the same offset as code 9, 0x0501.
- R4: Whenever `redir_o` is 1, `next_pc_o` equals `new_pc_o + 4`.
- R5: On a take, `exc_wr_o` is 1. `exc_wr_data_o` is `pc_i + 4` for code 12 and `pc_i` for every other code.
- R6: A take of code 0 while `pc_i[0]` is 1 does not write the restart address (`exc_wr_o` is 0).
- R7: `shadow_enter_o` is 1 on a take exactly when `pc_i[0]` is 0.
- R8: A return with `pc_i[0]` set gives `redir_o` 1, `new_pc_o = exc_addr_i`, `next_pc_o = exc_addr_i + 4` and `chk_intr_o` 1.
- R9: On a legal return, `shadow_exit_o` is 1 exactly when `exc_addr_i[0]` is 0.
- R10: A return with `pc_i[0]` clear raises `illegal_o` with no redirect and no interrupt-check pulse.
- R11: If `take_i` and `ret_i` are both high, the take is processed and the return is ignored.
- R12: Codes 14 and 15 are reserved. A take with them produces no output activity.
- R13: Every output reflects the strobe of the previous clock cycle and lasts one cycle. The data outputs are 0 when their strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_i | input | 1 | One-cycle strobe: take the event in `fault_code_i` |
| fault_code_i | input | 4 | Event code |
| ret_i | input | 1 | One-cycle strobe: privileged return executes |
| pc_i | input | XLEN | PC of the current instruction |
| pal_base_i | input | XLEN | Handler base address |
| exc_addr_i | input | XLEN | Saved restart address |
| redir_o | output | 1 | Redirect strobe |
| new_pc_o | output | XLEN | Redirect target |
| next_pc_o | output | XLEN | Address after the target |
| exc_wr_o | output | 1 | Restart-address write strobe |
| exc_wr_data_o | output | XLEN | Value to write |
| shadow_enter_o | output | 1 | Request to switch to the shadow bank |
| shadow_exit_o | output | 1 | Request to leave the shadow bank |
| illegal_o | output | 1 | Return executed outside privileged mode |
| chk_intr_o | output | 1 | Re-evaluate interrupts after a return |

## Verification
The assertions assume that `pc_i`, `fault_code_i` and `exc_addr_i` are valid whenever a strobe is high. They also assume that the strobes are single-cycle requests from a pipeline that does not replay them. The stimulus drives each input once per cycle on the falling edge. It walks every event code from both privileged and user PCs, and it issues legal and illegal returns with both values of the restart address's mode bit. It also places a take and a return in the same cycle, and it presents requests in the cycle that follows reset.

// File: rtl/pal_seq_pkg.sv
// Package: event codes and vector offsets shared by the sequencer.
// Assumes a 4-bit event code; offsets always carry the privileged bit.
package pal_seq_pkg;
    localparam int CODE_W = 4;
    localparam int OFS_W  = 14;

    localparam logic [CODE_W-1:0] EV_INTR     = 4'd0;
    localparam logic [CODE_W-1:0] EV_IMISS    = 4'd1;
    localparam logic [CODE_W-1:0] EV_IACV     = 4'd2;
    localparam logic [CODE_W-1:0] EV_DMISS_U  = 4'd3;
    localparam logic [CODE_W-1:0] EV_DMISS_P  = 4'd4;
    localparam logic [CODE_W-1:0] EV_ALIGN    = 4'd5;
    localparam logic [CODE_W-1:0] EV_DFAULT   = 4'd6;
    localparam logic [CODE_W-1:0] EV_MCHK     = 4'd7;
    localparam logic [CODE_W-1:0] EV_OPCODE   = 4'd8;
    localparam logic [CODE_W-1:0] EV_ARITH    = 4'd9;
    localparam logic [CODE_W-1:0] EV_IOVF     = 4'd10;
    localparam logic [CODE_W-1:0] EV_FPDIS    = 4'd11;
    localparam logic [CODE_W-1:0] EV_PCALL    = 4'd12;
    localparam logic [CODE_W-1:0] EV_RESET    = 4'd13;

    localparam int INSN_BYTES = 4;
endpackage

// File: rtl/pal_vec_lut.sv
// Module: maps an event code to its handler offset.
// Assumes codes above EV_RESET are reserved and reports them as unknown.
module pal_vec_lut
    import pal_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              known_o
);
    // Offset selection; integer overflow shares the arithmetic vector.
    always_comb begin
        known_o = 1'b1;
        unique case (code_i)
            EV_INTR:              ofs_o = 14'h0101;
            EV_IMISS:             ofs_o = 14'h0181;
            EV_IACV:              ofs_o = 14'h0081;
            EV_DMISS_U:           ofs_o = 14'h0201;
            EV_DMISS_P:           ofs_o = 14'h0281;
            EV_ALIGN:             ofs_o = 14'h0301;
            EV_DFAULT:            ofs_o = 14'h0381;
            EV_MCHK:              ofs_o = 14'h0401;
            EV_OPCODE:            ofs_o = 14'h0481;
            EV_ARITH, EV_IOVF:    ofs_o = 14'h0501;
            EV_FPDIS:             ofs_o = 14'h0581;
            EV_PCALL:             ofs_o = 14'h2001;
            EV_RESET:             ofs_o = 14'h0001;
            default: begin
                ofs_o   = '0;
                known_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pal_entry_calc.sv
// Module: combinational entry path. Produces the handler and follow-on
// addresses, the restart-address update and the shadow-entry decision.
// Assumes pc_i bit 0 marks privileged mode.
module pal_entry_calc
    import pal_seq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   base_i,
    output logic              known_o,
    output logic [XLEN-1:0]   target_o,
    output logic [XLEN-1:0]   follow_o,
    output logic              save_o,
    output logic [XLEN-1:0]   save_addr_o,
    output logic              enter_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [OFS_W-1:0] ofs;

    pal_vec_lut u_lut (
        .code_i  (code_i),
        .ofs_o   (ofs),
        .known_o (known_o)
    );

    // Address arithmetic and restart-address policy.
    always_comb begin
        target_o    = base_i + XLEN'(ofs);
        follow_o    = target_o + STEP;
        save_addr_o = (code_i == EV_PCALL) ? pc_i + STEP : pc_i;
        save_o      = !((code_i == EV_INTR) && pc_i[0]);
        enter_o     = !pc_i[0];
    end
endmodule

// File: rtl/pal_return_calc.sv
// Module: combinational return path. Checks legality and computes the
// return target and the shadow-exit decision.
// Assumes exc_addr_i bit 0 gives the mode being returned to.
module pal_return_calc
    import pal_seq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] exc_addr_i,
    output logic            legal_o,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] follow_o,
    output logic            leave_o
);
    // Return legality and destination.
    always_comb begin
        legal_o  = pc_i[0];
        target_o = exc_addr_i;
        follow_o = exc_addr_i + XLEN'(INSN_BYTES);
        leave_o  = !exc_addr_i[0];
    end
endmodule

// File: rtl/pal_seq_top.sv
// Module: registers the entry/return decisions as one-cycle strobes.
// After reset it issues the reset redirect once. A take outranks a return,
// and data outputs read 0 whenever their strobe is low.
module pal_seq_top
    import pal_seq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [CODE_W-1:0] fault_code_i,
    input  logic              ret_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   pal_base_i,
    input  logic [XLEN-1:0]   exc_addr_i,
    output logic              redir_o,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              exc_wr_o,
    output logic [XLEN-1:0]   exc_wr_data_o,
    output logic              shadow_enter_o,
    output logic              shadow_exit_o,
    output logic              illegal_o,
    output logic              chk_intr_o
);
    logic              boot_pend;
    logic [CODE_W-1:0] code_sel;
    logic              e_known, e_save, e_enter;
    logic [XLEN-1:0]   e_tgt, e_fol, e_sav;
    logic              r_legal, r_leave;
    logic [XLEN-1:0]   r_tgt, r_fol;

    // Reset vector reuses the entry adder.
    assign code_sel = boot_pend ? EV_RESET : fault_code_i;

    pal_entry_calc #(.XLEN(XLEN)) u_entry (
        .code_i      (code_sel),
        .pc_i        (pc_i),
        .base_i      (pal_base_i),
        .known_o     (e_known),
        .target_o    (e_tgt),
        .follow_o    (e_fol),
        .save_o      (e_save),
        .save_addr_o (e_sav),
        .enter_o     (e_enter)
    );

    pal_return_calc #(.XLEN(XLEN)) u_ret (
        .pc_i       (pc_i),
        .exc_addr_i (exc_addr_i),
        .legal_o    (r_legal),
        .target_o   (r_tgt),
        .follow_o   (r_fol),
        .leave_o    (r_leave)
    );

    // Output register: boot, then take, then return, in priority order.
    always_ff @(posedge clk) begin
        redir_o        <= 1'b0;
        new_pc_o       <= '0;
        next_pc_o      <= '0;
        exc_wr_o       <= 1'b0;
        exc_wr_data_o  <= '0;
        shadow_enter_o <= 1'b0;
        shadow_exit_o  <= 1'b0;
        illegal_o      <= 1'b0;
        chk_intr_o     <= 1'b0;
        if (!rst_n) begin
            boot_pend <= 1'b1;
        end else if (boot_pend) begin
            boot_pend      <= 1'b0;
            redir_o        <= 1'b1;
            new_pc_o       <= e_tgt;
            next_pc_o      <= e_fol;
            shadow_enter_o <= 1'b1;
        end else if (take_i) begin
            if (e_known) begin
                redir_o        <= 1'b1;
                new_pc_o       <= e_tgt;
                next_pc_o      <= e_fol;
                exc_wr_o       <= e_save;
                exc_wr_data_o  <= e_save ? e_sav : '0;
                shadow_enter_o <= e_enter;
            end
        end else if (ret_i) begin
            if (r_legal) begin
                redir_o       <= 1'b1;
                new_pc_o      <= r_tgt;
                next_pc_o     <= r_fol;
                shadow_exit_o <= r_leave;
                chk_intr_o    <= 1'b1;
            end else begin
                illegal_o <= 1'b1;
            end
        end
    end

    AST_FOLLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> next_pc_o == new_pc_o + XLEN'(INSN_BYTES)); // R4
    AST_PCALL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_pend && take_i && fault_code_i == EV_PCALL)
        |=> (exc_wr_o && exc_wr_data_o == $past(pc_i) + XLEN'(INSN_BYTES))); // R5
    AST_PAL_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_pend && take_i && fault_code_i == EV_INTR && pc_i[0]) |=> !exc_wr_o); // R6
    AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_pend && !take_i && ret_i && pc_i[0])
        |=> (redir_o && chk_intr_o && new_pc_o == $past(exc_addr_i))); // R8
    AST_ILLEGAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!redir_o && !chk_intr_o)); // R10
    AST_SHADOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shadow_enter_o, shadow_exit_o})); // R9
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_pend && take_i && fault_code_i > EV_RESET)
        |=> !(redir_o || exc_wr_o || illegal_o)); // R12
endmodule

// File: tb/tb_pal_seq_top.sv
`timescale 1ns/1ps
module tb_pal_seq_top;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic take_i = 1'b0;
    logic [3:0] fault_code_i = '0;
    logic ret_i = 1'b0;
    logic [XLEN-1:0] pc_i = '0, pal_base_i = '0, exc_addr_i = '0;
    logic redir_o, exc_wr_o, shadow_enter_o, shadow_exit_o, illegal_o, chk_intr_o;
    logic [XLEN-1:0] new_pc_o, next_pc_o, exc_wr_data_o;

    int n_chk = 0, n_fail = 0;
    bit boot_m = 1'b1;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pal_seq_top #(.XLEN(XLEN)) dut (.*);

    function automatic logic [XLEN-1:0] vec(input int c);
        case (c)
            0: return 64'h0101;   1: return 64'h0181;   2: return 64'h0081;
            3: return 64'h0201;   4: return 64'h0281;   5: return 64'h0301;
            6: return 64'h0381;   7: return 64'h0401;   8: return 64'h0481;
            9: return 64'h0501;  10: return 64'h0501;  11: return 64'h0581;
            12: return 64'h2001; 13: return 64'h0001;
            default: return 64'h0;
        endcase
    endfunction

    // Reference model: expected outputs after one edge, compared at negedge.
    task automatic cyc(input string tag);
        logic e_r, e_w, e_en, e_ex, e_il, e_ck;
        logic [XLEN-1:0] e_np, e_nn, e_wd;
        logic [197:0] got, exp;
        e_r = 0; e_w = 0; e_en = 0; e_ex = 0; e_il = 0; e_ck = 0;
        e_np = 0; e_nn = 0; e_wd = 0;
        if (!rst_n) begin
            boot_m = 1'b1;
        end else if (boot_m) begin
            boot_m = 1'b0;
            e_r = 1; e_np = pal_base_i + 64'h1; e_nn = e_np + 4; e_en = 1;
        end else if (take_i) begin
            if (fault_code_i <= 13) begin
                e_r = 1; e_np = pal_base_i + vec(int'(fault_code_i)); e_nn = e_np + 4;
                e_en = !pc_i[0];
                if (!(fault_code_i == 0 && pc_i[0])) begin
                    e_w = 1; e_wd = (fault_code_i == 12) ? pc_i + 4 : pc_i;
                end
            end
        end else if (ret_i) begin
            if (pc_i[0]) begin
                e_r = 1; e_np = exc_addr_i; e_nn = exc_addr_i + 4;
                e_ex = !exc_addr_i[0]; e_ck = 1;
            end else e_il = 1;
        end
        @(posedge clk);
        @(negedge clk);
        exp = {e_r, e_np, e_nn, e_w, e_wd, e_en, e_ex, e_il, e_ck};
        got = {redir_o, new_pc_o, next_pc_o, exc_wr_o, exc_wr_data_o,
               shadow_enter_o, shadow_exit_o, illegal_o, chk_intr_o};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        take_i = 0; ret_i = 0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        pal_base_i = 64'h0000_0000_0040_0000;
        repeat (3) cyc("R1 reset quiet");
        rst_n = 1;
        take_i = 1; fault_code_i = 4'd5; ret_i = 1; pc_i = 64'h1234_0000; // ignored at boot
        cyc("R1 boot redirect");
        idle();
        cyc("R13 pulse drops");
        // Every code from user mode: R2 R3 R4 R5 R7 R12
        for (int c = 0; c < 16; c++) begin
            take_i = 1; fault_code_i = 4'(c); pc_i = 64'h0000_1000_0000 + 64'(c * 16);
            cyc(c == 10 ? "R3 overflow vector" : (c > 13 ? "R12 reserved" : "R2 R5 R7 vector"));
            idle();
            cyc("R13 idle");
        end
        // Every code from privileged mode: R6 R7
        pal_base_i = 64'hFFFF_0000_0000_0000;
        for (int c = 0; c < 14; c++) begin
            take_i = 1; fault_code_i = 4'(c); pc_i = 64'h0040_2001 + 64'(c * 8);
            cyc(c == 0 ? "R6 interrupt in PAL" : "R7 no enter in PAL");
        end
        idle();
        // Returns: R8 R9 R10
        ret_i = 1; pc_i = 64'h0040_0101; exc_addr_i = 64'h0000_7000_0010;
        cyc("R8 R9 return to user");
        exc_addr_i = 64'h0040_3005;
        cyc("R9 return stays PAL");
        pc_i = 64'h0000_7000_0010;
        cyc("R10 illegal return");
        // Take and return together: R11
        take_i = 1; fault_code_i = 4'd12; pc_i = 64'h0000_0000_8000;
        cyc("R11 take wins");
        take_i = 1; fault_code_i = 4'd15;
        cyc("R11 reserved take still blocks return");
        // Mixed traffic
        for (int i = 0; i < 200; i++) begin
            take_i = ($urandom % 3) == 0;
            ret_i = ($urandom % 3) == 0;
            fault_code_i = 4'($urandom);
            pc_i = {$urandom, $urandom};
            exc_addr_i = {$urandom, $urandom};
            pal_base_i = {$urandom, $urandom} & ~64'h3FFF;
            cyc("R13 mixed traffic");
        end
        idle();
        rst_n = 0;
        cyc("R1 reset again");
        rst_n = 1;
        cyc("R1 boot after second reset");
        cyc("R13 idle after boot");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule